// File: doc/BRIEF.md
# Program Counter and Status Byte Register

This block holds the 32-bit program counter of a small 16-bit processor with separate instruction and data memories. Bits 23:0 hold the word address of the next instruction to fetch. Bits 31:24 form a status byte. Bit 24 of that byte is a carry flag, which supports multi-word add and subtract and never steers a branch. Bits 31:25 are reserved. They always read as zero and keep no written value.

Every clock the register takes one of four actions. It can hold. It can step past the current instruction, by one word for a 16-bit instruction or two words for a 32-bit one. It can load a branch or jump target. It can take a full 32-bit write. A jump changes only the address and leaves the status byte alone. The carry flag has its own update path from the ALU. There are no delay slots, so a taken jump decides the next fetch address on its own.

Top module: `pc_status_reg`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets the fetch address to 0 and clears carry, so `rd_data` reads 0.
- R2: With `adv_en` high, `adv_long` low and no jump or write, the address increases by 1 modulo 2^24. Address 0xFFFFFF steps to 0x000000.
- R3: With `adv_en` high and `adv_long` high, and no jump or write, the address increases by 2 modulo 2^24. Address 0xFFFFFE steps to 0, and 0xFFFFFF steps to 1.
- R4: A taken jump (`jmp_taken` high, `wr_en` low) loads `jmp_target[23:0]` into the address. Bits 31:24 of the target are ignored, and carry keeps its value unless `carry_we` changes it.
- R5: A taken jump overrides a sequential advance in the same cycle. The next fetch address is the target, with no delay slot.
- R6: With `carry_we` high and `wr_en` low, carry becomes `carry_in`. The address is unaffected by the carry update.
- R7: A full write (`wr_en` high) loads bits 23:0 of `wr_data` into the address and bit 24 into carry. `rd_data[31:25]` always reads 0, whatever was written.
- R8: A full write overrides a carry update, a jump and an advance in the same cycle.
- R9: With `wr_en`, `jmp_taken` and `adv_en` all low, the address holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| adv_en | input | 1 | Step past the current instruction |
| adv_long | input | 1 | Current instruction is 32-bit (step of 2 words) |
| jmp_taken | input | 1 | Load the jump or branch target |
| jmp_target | input | 32 | Target value; only bits 23:0 are used |
| carry_we | input | 1 | Carry update from the ALU |
| carry_in | input | 1 | New carry value |
| wr_en | input | 1 | Full 32-bit register write |
| wr_data | input | 32 | Write value: bits 23:0 address, bit 24 carry |
| rd_data | output | 32 | Full register read: {7'b0, carry, address} |
| fetch_addr | output | 24 | Instruction fetch word address |
| carry_out | output | 1 | Current carry flag |

## Verification
The assertions assume that control and data inputs are known, 0 or 1, at every clock edge after reset. They also assume that reset is high at the first edge, so that no check looks at pre-reset state. The bench drives every input at the falling edge from a fixed sequence, with no unknown values, and holds reset over the first edges. The stimulus steps through all 64 combinations of the six control inputs repeatedly. Targets and write data are steered near the top of the address space so that wrap-around is reached often.

// File: rtl/pc_status_pkg.sv
package pc_status_pkg;

    parameter int PC_ADDR_W = 24;
    parameter int PC_STAT_W = 8;

    typedef enum logic [1:0] {
        SRC_HOLD = 2'd0,
        SRC_SEQ  = 2'd1,
        SRC_JUMP = 2'd2,
        SRC_LOAD = 2'd3
    } addr_src_e;

endpackage

// File: rtl/pc_src_select.sv
module pc_src_select
    import pc_status_pkg::*;
(
    input  logic      wr_en,
    input  logic      jmp_taken,
    input  logic      adv_en,
    output addr_src_e src
);

    // Priority: full write, then jump, then sequential step.
    always_comb begin
        if (wr_en)          src = SRC_LOAD;
        else if (jmp_taken) src = SRC_JUMP;
        else if (adv_en)    src = SRC_SEQ;
        else                src = SRC_HOLD;
    end

endmodule

// File: rtl/pc_addr_next.sv
module pc_addr_next
    import pc_status_pkg::*;
#(
    parameter int ADDR_W = PC_ADDR_W
) (
    input  addr_src_e         src,
    input  logic [ADDR_W-1:0] cur_q,
    input  logic              adv_long,
    input  logic [ADDR_W-1:0] jump_addr,
    input  logic [ADDR_W-1:0] load_addr,
    output logic [ADDR_W-1:0] addr_d
);

    logic [ADDR_W-1:0] step;
    logic [ADDR_W-1:0] seq_addr;

    // Step of 1 or 2 words; the sum wraps naturally at 2^ADDR_W.
    assign step     = adv_long ? ADDR_W'(2) : ADDR_W'(1);
    assign seq_addr = cur_q + step;

    always_comb begin
        unique case (src)
            SRC_LOAD: addr_d = load_addr;
            SRC_JUMP: addr_d = jump_addr;
            SRC_SEQ:  addr_d = seq_addr;
            default:  addr_d = cur_q;
        endcase
    end

endmodule

// File: rtl/pc_carry_next.sv
module pc_carry_next (
    input  logic cur_q,
    input  logic wr_en,
    input  logic wr_bit,
    input  logic carry_we,
    input  logic carry_in,
    output logic carry_d
);

    // A full write beats an ALU carry update in the same cycle.
    always_comb begin
        if (wr_en)         carry_d = wr_bit;
        else if (carry_we) carry_d = carry_in;
        else               carry_d = cur_q;
    end

endmodule

// File: rtl/pc_status_reg.sv
module pc_status_reg
    import pc_status_pkg::*;
#(
    parameter int ADDR_W = PC_ADDR_W,
    parameter int STAT_W = PC_STAT_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       adv_en,
    input  logic                       adv_long,
    input  logic                       jmp_taken,
    input  logic [ADDR_W+STAT_W-1:0]   jmp_target,
    input  logic                       carry_we,
    input  logic                       carry_in,
    input  logic                       wr_en,
    input  logic [ADDR_W+STAT_W-1:0]   wr_data,
    output logic [ADDR_W+STAT_W-1:0]   rd_data,
    output logic [ADDR_W-1:0]          fetch_addr,
    output logic                       carry_out
);

    localparam int REG_W     = ADDR_W + STAT_W;
    localparam int CARRY_POS = ADDR_W;
    localparam int PAD_W     = STAT_W - 1;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              carry;
    } pc_state_t;

    pc_state_t state_d, state_q;
    addr_src_e src;
    logic [ADDR_W-1:0] addr_d;
    logic carry_d;

    // Upper target bits and reserved write bits are dropped on purpose.
    logic unused_hi;
    assign unused_hi = ^{jmp_target[REG_W-1:ADDR_W], wr_data[REG_W-1:CARRY_POS+1]};

    pc_src_select u_sel (
        .wr_en     (wr_en),
        .jmp_taken (jmp_taken),
        .adv_en    (adv_en),
        .src       (src)
    );

    pc_addr_next #(.ADDR_W(ADDR_W)) u_addr (
        .src       (src),
        .cur_q     (state_q.addr),
        .adv_long  (adv_long),
        .jump_addr (jmp_target[ADDR_W-1:0]),
        .load_addr (wr_data[ADDR_W-1:0]),
        .addr_d    (addr_d)
    );

    pc_carry_next u_carry (
        .cur_q    (state_q.carry),
        .wr_en    (wr_en),
        .wr_bit   (wr_data[CARRY_POS]),
        .carry_we (carry_we),
        .carry_in (carry_in),
        .carry_d  (carry_d)
    );

    always_comb begin
        state_d = state_q;
        if (rst) begin
            state_d.addr  = '0;
            state_d.carry = 1'b0;
        end else begin
            state_d.addr  = addr_d;
            state_d.carry = carry_d;
        end
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign fetch_addr = state_q.addr;
    assign carry_out  = state_q.carry;
    assign rd_data    = {{PAD_W{1'b0}}, state_q.carry, state_q.addr};

    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!wr_en && !jmp_taken && !adv_en) |=> $stable(fetch_addr));

    assert_short_step_R2: assert property (@(posedge clk) disable iff (rst)
        (adv_en && !adv_long && !jmp_taken && !wr_en)
        |=> fetch_addr == ADDR_W'($past(fetch_addr) + ADDR_W'(1)));

    assert_long_step_R3: assert property (@(posedge clk) disable iff (rst)
        (adv_en && adv_long && !jmp_taken && !wr_en)
        |=> fetch_addr == ADDR_W'($past(fetch_addr) + ADDR_W'(2)));

    assert_jump_keeps_carry_R4: assert property (@(posedge clk) disable iff (rst)
        (jmp_taken && !wr_en && !carry_we)
        |=> (fetch_addr == $past(jmp_target[ADDR_W-1:0])) && $stable(carry_out));

    assert_carry_update_R6: assert property (@(posedge clk) disable iff (rst)
        (carry_we && !wr_en) |=> carry_out == $past(carry_in));

    assert_write_wins_R8: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (carry_out == $past(wr_data[CARRY_POS]))
               && (fetch_addr == $past(wr_data[ADDR_W-1:0])));

endmodule

// File: tb/pc_status_reg_test.sv
`timescale 1ns/1ps
module pc_status_reg_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        adv_en, adv_long, jmp_taken, carry_we, carry_in, wr_en;
    logic [31:0] jmp_target, wr_data, rd_data;
    logic [23:0] fetch_addr;
    logic        carry_out;

    int checks = 0;
    int errors = 0;
    logic [23:0] exp_addr;
    logic        exp_c;
    logic [31:0] lfsr = 32'h1D2C_3B4A;

    always #10 clk = ~clk;   // 50 MHz

    pc_status_reg uut (
        .clk(clk), .rst(rst), .adv_en(adv_en), .adv_long(adv_long),
        .jmp_taken(jmp_taken), .jmp_target(jmp_target), .carry_we(carry_we),
        .carry_in(carry_in), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .fetch_addr(fetch_addr), .carry_out(carry_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        adv_en = 0; adv_long = 0; jmp_taken = 0; carry_we = 0;
        carry_in = 0; wr_en = 0; jmp_target = '0; wr_data = '0;
    endtask

    // Reference model: next state from the requirements.
    task automatic model_step();
        if (rst) begin
            exp_addr = '0; exp_c = 0;
        end else begin
            if (wr_en)          exp_addr = wr_data[23:0];
            else if (jmp_taken) exp_addr = jmp_target[23:0];
            else if (adv_en)    exp_addr = exp_addr + (adv_long ? 24'd2 : 24'd1);
            if (wr_en)          exp_c = wr_data[24];
            else if (carry_we)  exp_c = carry_in;
        end
    endtask

    function automatic string addr_req();
        if (rst)            return "R1";
        if (wr_en)          return "R8";
        if (jmp_taken)      return adv_en ? "R5" : "R4";
        if (adv_en)         return adv_long ? "R3" : "R2";
        return "R9";
    endfunction

    function automatic string carry_req();
        if (rst)      return "R1";
        if (wr_en)    return carry_we ? "R8" : "R7";
        if (carry_we) return "R6";
        return jmp_taken ? "R4" : "R9";
    endfunction

    // Drive at negedge, sample at the following negedge.
    task automatic cycle_and_check();
        string ra, rc;
        ra = addr_req();
        rc = carry_req();
        model_step();
        @(negedge clk);
        check(ra, {8'h0, fetch_addr}, {8'h0, exp_addr});
        check(rc, {31'h0, carry_out}, {31'h0, exp_c});
        check("R7", rd_data, {7'h0, exp_c, exp_addr});
    endtask

    initial begin
        idle();
        rst = 1;
        @(negedge clk); @(negedge clk);
        exp_addr = '0; exp_c = 0;
        check("R1", rd_data, 32'h0);
        check("R1", {31'h0, carry_out}, 32'h0);

        // Directed wrap corners.
        rst = 0;
        wr_en = 1; wr_data = 32'hFFFF_FFFF;           // R7: pad bits must read 0
        cycle_and_check();
        wr_en = 0; adv_en = 1;                        // R2 wrap FFFFFF -> 0
        cycle_and_check();
        jmp_target = 32'hA5FF_FFFE; jmp_taken = 1; adv_en = 0;   // R4 upper ignored
        cycle_and_check();
        jmp_taken = 0; adv_en = 1; adv_long = 1;      // R3 FFFFFE -> 0
        cycle_and_check();
        jmp_target = 32'h00FF_FFFF; jmp_taken = 1;    // R5 jump beats advance
        cycle_and_check();
        jmp_taken = 0;                                // R3 FFFFFF -> 1
        cycle_and_check();
        carry_we = 1; carry_in = 0; adv_en = 0;       // R6
        cycle_and_check();
        carry_we = 1; carry_in = 1; wr_en = 1; wr_data = 32'h0012_3456;  // R8
        cycle_and_check();
        idle();                                       // R9 hold
        cycle_and_check();

        // Sweep all control combinations with varied data.
        for (int i = 0; i < 8192; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            {wr_en, jmp_taken, adv_en, adv_long, carry_we, carry_in} = i[5:0];
            if (i[5:0] == 6'd0) wr_en = (lfsr[3:0] == 4'd0);
            jmp_target = i[6] ? {lfsr[31:24], 22'h3FFFFF, lfsr[1:0]} : lfsr;
            wr_data    = i[7] ? {lfsr[31:24], 22'h3FFFFF, lfsr[5:4]} : ~lfsr;
            rst = (i % 1000) == 999;
            cycle_and_check();
        end
        rst = 0;
        idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #4_000_000;
        errors++;
        $display("FAIL watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule